// File: doc/BRIEF.md
# Block Memory Copy Engine

This block copies a run of bytes from one place in a byte-wide memory to another. A start pulse supplies a source pointer, a destination pointer, a 16-bit byte count and a mode. Each step does three things: it reads one byte at the source, writes that byte at the destination, and then moves both pointers and lowers the count by one. The mode selects whether the pointers move up or down and whether the engine stops after one step or keeps stepping until the count is exhausted.

A skip mode compares each byte read with an 8-bit accumulator value and suppresses the write when they match. The pointers and the count still advance in that case. The engine takes a processor-style flag byte in at start and hands it back with the half-carry and subtract flags cleared and the parity/overflow flag showing whether bytes remain. The memory port has a fixed one-cycle read latency. Step timing is fixed so that a surrounding core keeps its cycle accounting.

Top module: `block_copy_engine`

## Requirements
- R1: In the first cycle of a step the engine asserts `mem_rd` with `mem_addr` equal to the source pointer. In the third cycle it asserts `mem_wr` with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte returned one cycle after the read. `mem_rd` and `mem_wr` are never high together.
- R2: At the end of each step the count drops by one, modulo 2^16. When `dir_down`=0 both pointers add one, and when it is 1 both subtract one, wrapping at 16 bits.
- R3: When `rep_mode`=0 exactly one step is done. When `rep_mode`=1 steps continue until the count after a step is zero.
- R4: When `skip_eq`=1, a byte equal to `acc` is not written (`mem_wr` stays low for that step), while the pointers and the count still update.
- R5: The flag byte uses bit 7 S, 6 Z, 5 and 3 spare, 4 H, 2 P/V, 1 N, 0 C. `flags_in` is loaded at start. Each step clears bits 4 and 1 and leaves bits 7, 6, 5, 3 and 0 unchanged.
- R6: After each step bit 2 of `flags_out` is 1 if the new count is nonzero and 0 if it is zero, so a repeat run ends with it cleared.
- R7: A single step keeps `busy` high for 16 cycles. In repeat mode each non-final step takes 21 cycles and the final one takes 16. `done` is high for exactly one cycle, right after `busy` falls.
- R8: Starting repeat mode with a count of zero performs a 21-cycle step, leaves the count at 0xFFFF with P/V set, and continues.
- R9: A `start` pulse while `busy` is high is ignored: pointers, count and the run length are unaffected.
- R10: After reset the pointers, the count and `flags_out` are zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| rep_mode | input | 1 | 1: repeat until count is zero |
| dir_down | input | 1 | 1: pointers decrement |
| skip_eq | input | 1 | 1: suppress writes of bytes equal to acc |
| acc | input | 8 | Accumulator value for skip compare |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| cnt_init | input | 16 | Byte count loaded at start |
| flags_in | input | 8 | Flag byte loaded at start |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, data valid next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Remaining byte count |
| flags_out | output | 8 | Updated flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The copy is tried in four patterns:
- Single steps that end with the count nonzero and with it zero, which separate the P/V rule from the step rule.
- Repeat runs going up and going down, which show pointer direction and the 21/16 cycle split.
- A repeat run with skip mode and one matching byte in the middle, which separates the suppressed write from the pointer and count update.
- Pointers at 0xFFFF and 0x0000, together with a repeat started at count zero, which exercise 16-bit wraparound.

A start pulse issued in the middle of a run shows that a busy engine keeps its original operands.

// File: rtl/block_copy_engine.sv
module block_copy_engine #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SHORT_CYC = 16,
  parameter int LONG_CYC  = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rep_mode,
  input  logic          dir_down,
  input  logic          skip_eq,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [AW-1:0] cnt_init,
  input  logic [7:0]    flags_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [AW-1:0] count,
  output logic [7:0]    flags_out,
  output logic          busy,
  output logic          done
);
  localparam int PW = $clog2(LONG_CYC);

  logic [AW-1:0] src_q, dst_q, cnt_q;
  logic [7:0]    flg_q;
  logic [DW-1:0] data_q, acc_q;
  logic [PW-1:0] phase_q, last_ph;
  logic          busy_q, done_q, rep_q, dec_q, skip_q;

  wire [AW-1:0] cnt_dec  = cnt_q - AW'(1);
  wire          step_end = busy_q && (phase_q == last_ph);

  assign last_ph   = (rep_q && cnt_q != AW'(1)) ? PW'(LONG_CYC - 1) : PW'(SHORT_CYC - 1);
  assign mem_rd    = busy_q && (phase_q == '0);
  assign mem_wr    = busy_q && (phase_q == PW'(2)) && !(skip_q && data_q == acc_q);
  assign mem_addr  = (phase_q == '0) ? src_q : dst_q;
  assign mem_wdata = data_q;
  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign count     = cnt_q;
  assign flags_out = flg_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; flg_q <= '0;
      data_q <= '0; acc_q <= '0; phase_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
      rep_q <= 1'b0; dec_q <= 1'b0; skip_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          src_q   <= src_init;
          dst_q   <= dst_init;
          cnt_q   <= cnt_init;
          flg_q   <= flags_in;
          acc_q   <= acc;
          rep_q   <= rep_mode;
          dec_q   <= dir_down;
          skip_q  <= skip_eq;
          phase_q <= '0;
          busy_q  <= 1'b1;
        end
      end else begin
        if (phase_q == PW'(1)) data_q <= mem_rdata;
        if (step_end) begin
          src_q   <= dec_q ? src_q - AW'(1) : src_q + AW'(1);
          dst_q   <= dec_q ? dst_q - AW'(1) : dst_q + AW'(1);
          cnt_q   <= cnt_dec;
          flg_q   <= {flg_q[7:5], 1'b0, flg_q[3], cnt_dec != '0, 1'b0, flg_q[0]};
          phase_q <= '0;
          if (!(rep_q && cnt_dec != '0)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          phase_q <= phase_q + PW'(1);
        end
      end
    end
  end

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));

  // R1
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(mem_rd, 2));

  // R2
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> count == $past(count) - AW'(1));

  // R4
  skip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !(skip_q && mem_wdata == acc_q));

  // R5
  hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> (flags_out[4] == 1'b0 && flags_out[1] == 1'b0));

  // R6
  pv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2] == (count != '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_end) |=> ($stable(src_ptr) && $stable(count)));
endmodule

// File: tb/block_copy_engine_tb.sv
module block_copy_engine_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, rep_mode, dir_down, skip_eq;
  logic [7:0]  acc, flags_in, mem_rdata, mem_wdata, flags_out;
  logic [15:0] src_init, dst_init, cnt_init, mem_addr, src_ptr, dst_ptr, count;
  logic        mem_rd, mem_wr, busy, done;

  block_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rep_mode(rep_mode), .dir_down(dir_down),
    .skip_eq(skip_eq), .acc(acc), .src_init(src_init), .dst_init(dst_init),
    .cnt_init(cnt_init), .flags_in(flags_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .count(count), .flags_out(flags_out), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] mem [int];

  function automatic logic [7:0] rdmem(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // reference model
  bit          m_busy, m_done, m_rep, m_dec, m_skip;
  int          k, m_len;
  logic [15:0] m_src, m_dst, m_cnt;
  logic [7:0]  m_flags, m_acc, m_byte;

  function automatic int iter_len(input bit rep, input logic [15:0] c);
    logic [15:0] t;
    t = c - 16'd1;
    return (rep && t != 16'd0) ? 21 : 16;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (mem_rd) mem_rdata <= rdmem(mem_addr);
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; k = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_flags = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (k == 0) m_byte = rdmem(m_src);
        if (k == m_len - 1) begin
          m_src = m_dec ? m_src - 16'd1 : m_src + 16'd1;
          m_dst = m_dec ? m_dst - 16'd1 : m_dst + 16'd1;
          m_cnt = m_cnt - 16'd1;
          m_flags[4] = 1'b0; m_flags[1] = 1'b0; m_flags[2] = (m_cnt != 0);
          if (m_rep && m_cnt != 0) begin k = 0; m_len = iter_len(m_rep, m_cnt); end
          else begin m_busy = 0; m_done = 1; end
        end else k++;
      end else if (start) begin
        m_src = src_init; m_dst = dst_init; m_cnt = cnt_init; m_flags = flags_in;
        m_rep = rep_mode; m_dec = dir_down; m_skip = skip_eq; m_acc = acc;
        m_busy = 1; k = 0; m_len = iter_len(rep_mode, cnt_init);
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit ew;
      ew = m_busy && k == 2 && !(m_skip && m_byte == m_acc);
      chk(src_ptr == m_src && dst_ptr == m_dst, "R2 pointers", {src_ptr, dst_ptr}, {m_src, m_dst});
      chk(count == m_cnt, "R2 count", count, m_cnt);
      chk(flags_out[7:3] == m_flags[7:3] && flags_out[1:0] == m_flags[1:0], "R5 flags", flags_out, m_flags);
      chk(flags_out[2] == m_flags[2], "R6 pv", flags_out, m_flags);
      chk(busy == m_busy && done == m_done, "R7 busy/done", {busy, done}, {m_busy, m_done});
      chk(mem_rd == (m_busy && k == 0), "R1 read strobe", mem_rd, m_busy && k == 0);
      if (m_busy && k == 0) chk(mem_addr == m_src, "R1 read addr", mem_addr, m_src);
      chk(mem_wr == ew, "R4 write strobe", mem_wr, ew);
      if (ew) chk(mem_addr == m_dst && mem_wdata == m_byte, "R1 write addr/data",
                  {mem_addr, mem_wdata}, {m_dst, m_byte});
    end
  end

  int busy_cyc, wr_cnt;

  task automatic op(input logic [15:0] s, d, c, input bit r, dn, sk, input logic [7:0] a, f);
    @(negedge clk);
    src_init = s; dst_init = d; cnt_init = c; rep_mode = r; dir_down = dn;
    skip_eq = sk; acc = a; flags_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cyc = 0; wr_cnt = 0;
    forever begin
      if (busy) busy_cyc++;
      if (mem_wr) wr_cnt++;
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rep_mode = 1'b0; dir_down = 1'b0; skip_eq = 1'b0;
    acc = 8'h00; flags_in = 8'h00; src_init = '0; dst_init = '0; cnt_init = '0;
    mem_rdata = 8'h00;
    for (int i = 16'h0100; i < 16'h0140; i++) mem[i] = pat(16'(i));
    mem[16'hFFFF] = pat(16'hFFFF);
    mem[0] = pat(16'h0000);
    for (int i = 16'h0340; i < 16'h0345; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0 && flags_out == 0, "R10 regs", {src_ptr, count}, 0);
    chk(!busy && !done && !mem_rd && !mem_wr, "R10 strobes", {busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;

    // single increment step, count stays nonzero
    op(16'h0100, 16'h0300, 16'd3, 0, 0, 0, 8'h00, 8'hFF);
    chk(busy_cyc == 16, "R7 single length", busy_cyc, 16);
    chk(count == 16'd2 && src_ptr == 16'h0101 && dst_ptr == 16'h0301, "R3 single step", count, 2);
    chk(flags_out == 8'hED, "R5 flags after step", flags_out, 8'hED);
    chk(rdmem(16'h0300) == pat(16'h0100), "R1 copied byte", rdmem(16'h0300), pat(16'h0100));

    // single decrement step reaching zero
    op(16'h0105, 16'h0305, 16'd1, 0, 1, 0, 8'h00, 8'h04);
    chk(src_ptr == 16'h0104 && dst_ptr == 16'h0304, "R2 decrement", src_ptr, 16'h0104);
    chk(flags_out[2] == 1'b0, "R6 pv cleared at zero", flags_out, 8'h00);

    // repeat increment, 3 bytes
    op(16'h0110, 16'h0320, 16'd3, 1, 0, 0, 8'h00, 8'hC5);
    chk(busy_cyc == 58, "R7 repeat length", busy_cyc, 58);
    chk(count == 0 && flags_out == 8'hC1, "R3 repeat end", {count, flags_out}, {16'h0, 8'hC1});
    for (int i = 0; i < 3; i++)
      chk(rdmem(16'h0320 + 16'(i)) == pat(16'h0110 + 16'(i)), "R3 repeat data",
          rdmem(16'h0320 + 16'(i)), pat(16'h0110 + 16'(i)));

    // repeat decrement with skip on middle byte
    op(16'h0124, 16'h0344, 16'd5, 1, 1, 1, pat(16'h0122), 8'h00);
    chk(busy_cyc == 100, "R7 repeat down length", busy_cyc, 100);
    chk(wr_cnt == 4, "R4 writes suppressed", wr_cnt, 4);
    chk(rdmem(16'h0342) == 8'hEE, "R4 skipped dest untouched", rdmem(16'h0342), 8'hEE);
    chk(rdmem(16'h0340) == pat(16'h0120), "R4 other bytes copied", rdmem(16'h0340), pat(16'h0120));
    chk(src_ptr == 16'h011F && count == 0, "R4 pointers still moved", src_ptr, 16'h011F);

    // repeat with count one is a single short step
    op(16'h0130, 16'h0330, 16'd1, 1, 0, 0, 8'h00, 8'h00);
    chk(busy_cyc == 16, "R7 repeat final only", busy_cyc, 16);

    // pointer wraparound in both directions
    op(16'hFFFF, 16'h0400, 16'd2, 0, 0, 0, 8'h00, 8'h00);
    chk(src_ptr == 16'h0000, "R2 increment wrap", src_ptr, 0);
    op(16'h0000, 16'h0000, 16'd2, 0, 1, 0, 8'h00, 8'h00);
    chk(src_ptr == 16'hFFFF && dst_ptr == 16'hFFFF, "R2 decrement wrap", {src_ptr, dst_ptr}, 32'hFFFFFFFF);

    // start while busy is ignored
    @(negedge clk);
    src_init = 16'h0100; dst_init = 16'h0500; cnt_init = 16'd7; rep_mode = 0; dir_down = 0;
    skip_eq = 0; flags_in = 8'h00; start = 1'b1;
    @(negedge clk);
    src_init = 16'h0800; cnt_init = 16'd40; rep_mode = 1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    chk(src_ptr == 16'h0100 && count == 16'd7, "R9 operands kept", {src_ptr, count}, {16'h0100, 16'd7});
    while (!done) @(negedge clk);
    chk(count == 16'd6 && src_ptr == 16'h0101, "R9 single step only", count, 6);

    // repeat from count zero wraps
    op_zero();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && count == 0, "R10 reset mid-run", {busy, count}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic op_zero();
    @(negedge clk);
    src_init = 16'h0100; dst_init = 16'h0600; cnt_init = 16'd0; rep_mode = 1; dir_down = 0;
    skip_eq = 0; flags_in = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (21) @(negedge clk);
    chk(count == 16'hFFFF && flags_out[2] && busy, "R8 wrap to FFFF", count, 16'hFFFF);
    repeat (21) @(negedge clk);
    chk(count == 16'hFFFE && busy, "R8 run continues", count, 16'hFFFE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule